// File: doc/BRIEF.md
# Configurable 16-Pin GPIO Port Controller

This block is one general-purpose I/O port of sixteen pins behind a small word-addressed register bus. Software gives every pin a 4-bit setting that makes it an input (analog, floating or pulled) or an output. An output can be push-pull or open-drain, can run at one of three speed grades, and is driven either from the port's output latch or from an on-chip peripheral. The pad-side ports carry the pad level in, the driven level out, the output enable and the pull-up and pull-down requests. Each pin also has a peripheral data input and a peripheral drive-enable input.

Software can set or clear any output bit with a single write, so an interrupt handler can never lose an update made by the code it interrupted. A keyed sequence on the lock register freezes the settings of chosen pins until the next reset. Pad levels pass through a synchronizer before software can read them. A pin in analog mode always reads zero.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin setting is 4'b0100 (floating input), so word addresses 0 and 1 both read 32'h4444_4444. The output latch, the lock word, pad_oe, pad_pu and pad_pd are all zero.
- R2: The setting of pin p sits at word address 0 for p<8 and at word address 1 for p>=8, in bits [4*(p%8)+3 : 4*(p%8)]. Within a setting, bits [1:0] are the mode (00 input; 01, 10 and 11 are outputs of three speed grades) and bits [3:2] are the configuration. A write replaces every unlocked setting in the addressed word, and a read returns the settings.
- R3: Word address 3 is the output latch. A write stores bits [15:0], and a read returns them with bits [31:16] as zero. Word address 2 returns the sampled input levels in bits [15:0], with zeros above.
- R4: A write to word address 4 sets output bit i where data bit i is 1 and clears it where data bit 16+i is 1. When both are 1, the bit is set. Bits with neither are unchanged. Word address 4 reads as zero.
- R5: An output pin with configuration 00 (push-pull, latch source) asserts pad_oe and drives pad_out from its output latch bit, at every output speed grade.
- R6: An output pin with configuration 01 (open-drain, latch source) never drives pad_out high. It asserts pad_oe only while its latch bit is 0.
- R7: An output pin with configuration 1x takes its level from alt_out and gates its drive with alt_oe. With 10 it drives push-pull; with 11 it drives open-drain (enable only while alt_out is 0).
- R8: An input pin never asserts pad_oe. With configuration 10 it requests pull-up when its latch bit is 1 and pull-down when it is 0. With configuration 00, 01 or 11 it requests no pull.
- R9: An input pin with configuration 00 (analog) reads 0 at word address 2, whatever its pad level.
- R10: A change on pad_in shows at word address 2 on the third rising clock edge after it, and not before.
- R11: Three writes to word address 5 commit a lock when the bus then reads word address 5. The writes are: bit 16 set with pin mask M, then bit 16 clear with the same M, then bit 16 set with the same M. The commit locks the pins in M, and later writes leave those settings unchanged. Word address 5 reads the locked pins in bits [15:0], and bit 16 reads 1 once any pin is locked.
- R12: Any other access to word address 5 before the commit abandons the sequence without locking anything: a wrong key bit, a changed mask, or a read too early. Locks are never released except by reset, and unlocked pins stay writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe, one per clock cycle |
| bus_re | input | 1 | Read strobe, which steps the lock sequence |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| pad_in | input | 16 | Pad levels, asynchronous |
| pad_out | output | 16 | Level driven onto each pad |
| pad_oe | output | 16 | Output enable for each pad |
| pad_pu | output | 16 | Pull-up request for each pad |
| pad_pd | output | 16 | Pull-down request for each pad |
| alt_out | input | 16 | Peripheral data for each pin |
| alt_oe | input | 16 | Peripheral drive enable for each pin |

## Verification
Pin settings are exercised in every class the port supports: push-pull output at two speed grades, open-drain with the latch at both levels, peripheral-sourced output in both drive styles with its enable both on and off, pulled input in both directions, floating input, and analog input. This separates a swapped configuration bit from a wrong mode decode. Set/clear writes cover set only, clear only, and both on one bit; the last shows whether set really takes priority. The lock tests run one correct sequence and three broken ones: a wrong key, a changed mask, and a read too early. After each, a write shows whether a pin was wrongly locked or a locked pin wrongly changed. A final reset shows that the locks are released.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned NPINS          = 16;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned FIELD_W        = 4;
  localparam int unsigned FIELDS_PER_REG = DATA_W / FIELD_W;
  localparam int unsigned ADDR_W         = 3;
  localparam int unsigned LOCK_KEY_BIT   = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG_LO = 3'd0,
    A_CFG_HI = 3'd1,
    A_IN     = 3'd2,
    A_OUT    = 3'd3,
    A_SETCLR = 3'd4,
    A_LOCK   = 3'd5
  } reg_addr_e;

  // setting layout: [3:2] configuration, [1:0] mode
  localparam logic [FIELD_W-1:0] CFG_RESET = 4'b0100;

  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_ARMED   = 2'd1,
    LK_CLEARED = 2'd2,
    LK_READY   = 2'd3
  } lock_state_e;

endpackage

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
  import gpio_port_pkg::*;
#(
  parameter int unsigned N   = NPINS,
  parameter int unsigned KEY = LOCK_KEY_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [KEY:0] data_i,
  output logic         commit_o,
  output logic [N-1:0] mask_o
);

  lock_state_e  state_q, state_d;
  logic [N-1:0] mask_q, mask_d;
  logic         mask_en;
  logic         same_mask;

  assign same_mask = (data_i[N-1:0] == mask_q);

  always_comb begin
    state_d  = state_q;
    mask_d   = mask_q;
    mask_en  = 1'b0;
    commit_o = 1'b0;
    case (state_q)
      LK_IDLE: begin
        if (wr_i && data_i[KEY]) begin
          state_d = LK_ARMED;
          mask_d  = data_i[N-1:0];
          mask_en = 1'b1;
        end
      end
      LK_ARMED: begin
        if (wr_i)      state_d = (!data_i[KEY] && same_mask) ? LK_CLEARED : LK_IDLE;
        else if (rd_i) state_d = LK_IDLE;
      end
      LK_CLEARED: begin
        if (wr_i)      state_d = (data_i[KEY] && same_mask) ? LK_READY : LK_IDLE;
        else if (rd_i) state_d = LK_IDLE;
      end
      LK_READY: begin
        if (rd_i) begin
          commit_o = 1'b1;
          state_d  = LK_IDLE;
        end else if (wr_i) begin
          state_d = LK_IDLE;
        end
      end
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  // R12: the sequence cannot leap from idle past its middle steps
  assert_no_skip_from_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_IDLE) |=> (state_q != LK_CLEARED && state_q != LK_READY));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned N = NPINS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic                          re_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [N-1:0]                  idr_i,
  output logic [N-1:0][FIELD_W-1:0]     cfg_o,
  output logic [N-1:0]                  odr_o
);

  localparam int unsigned PAD_W = DATA_W - N;

  logic [N-1:0][FIELD_W-1:0] cfg_q, cfg_d;
  logic [N-1:0]              odr_q, odr_d;
  logic [N-1:0]              lock_q, lock_d;
  logic                      cfg_en, odr_en, lock_en;
  logic                      wr_cfg_lo, wr_cfg_hi, wr_out, wr_setclr, wr_lock, rd_lock;
  logic                      commit;
  logic [N-1:0]              commit_mask;

  assign wr_cfg_lo = we_i && (addr_i == A_CFG_LO);
  assign wr_cfg_hi = we_i && (addr_i == A_CFG_HI);
  assign wr_out    = we_i && (addr_i == A_OUT);
  assign wr_setclr = we_i && (addr_i == A_SETCLR);
  assign wr_lock   = we_i && (addr_i == A_LOCK);
  assign rd_lock   = re_i && (addr_i == A_LOCK);

  gpio_lock_seq #(.N(N), .KEY(LOCK_KEY_BIT)) u_lock_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_lock),
    .rd_i     (rd_lock),
    .data_i   (wdata_i[LOCK_KEY_BIT:0]),
    .commit_o (commit),
    .mask_o   (commit_mask)
  );

  // next-state: settings
  always_comb begin
    cfg_d = cfg_q;
    for (int p = 0; p < N; p++) begin
      if (!lock_q[p]) begin
        if (p < FIELDS_PER_REG) begin
          if (wr_cfg_lo) cfg_d[p] = wdata_i[FIELD_W*(p%FIELDS_PER_REG) +: FIELD_W];
        end else begin
          if (wr_cfg_hi) cfg_d[p] = wdata_i[FIELD_W*(p%FIELDS_PER_REG) +: FIELD_W];
        end
      end
    end
  end
  assign cfg_en = wr_cfg_lo || wr_cfg_hi;

  // next-state: output latch, set has priority over clear
  always_comb begin
    odr_d = odr_q;
    if (wr_out)         odr_d = wdata_i[N-1:0];
    else if (wr_setclr) odr_d = (odr_q & ~wdata_i[N +: N]) | wdata_i[N-1:0];
  end
  assign odr_en = wr_out || wr_setclr;

  // next-state: locks accumulate
  assign lock_d  = lock_q | commit_mask;
  assign lock_en = commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= {N{CFG_RESET}};
      odr_q  <= '0;
      lock_q <= '0;
    end else begin
      if (cfg_en)  cfg_q  <= cfg_d;
      if (odr_en)  odr_q  <= odr_d;
      if (lock_en) lock_q <= lock_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CFG_LO: rdata_o = cfg_q[FIELDS_PER_REG-1:0];
      A_CFG_HI: rdata_o = cfg_q[N-1:FIELDS_PER_REG];
      A_IN:     rdata_o = {{PAD_W{1'b0}}, idr_i};
      A_OUT:    rdata_o = {{PAD_W{1'b0}}, odr_q};
      A_LOCK:   rdata_o = {{(PAD_W-1){1'b0}}, |lock_q, lock_q};
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign odr_o = odr_q;

  // R12: only a read of the lock word may change the lock state
  assert_lock_needs_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lock |=> $stable(lock_q));

  for (genvar p = 0; p < N; p++) begin : g_chk
    assert_locked_field_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[p] |=> $stable(cfg_q[p]));
    assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[p] |=> lock_q[p]);
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_setclr && wdata_i[p]) |=> odr_q[p]);
    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_setclr && wdata_i[N+p] && !wdata_i[p]) |=> !odr_q[p]);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
#(
  parameter int unsigned N      = NPINS,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_i,
  input  logic [N-1:0] analog_i,
  output logic [N-1:0] idr_o
);

  logic [N-1:0] chain_q [STAGES];
  logic [N-1:0] idr_q, idr_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= pad_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign idr_d = chain_q[STAGES-1] & ~analog_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idr_q <= '0;
    else        idr_q <= idr_d;
  end

  assign idr_o = idr_q;

  for (genvar p = 0; p < N; p++) begin : g_chk
    assert_analog_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      analog_i[p] |=> !idr_q[p]);
  end

endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_port_pkg::*;
(
  input  logic [FIELD_W-1:0] cfg_i,
  input  logic               odr_i,
  input  logic               alt_out_i,
  input  logic               alt_oe_i,
  output logic               pad_out_o,
  output logic               pad_oe_o,
  output logic               pad_pu_o,
  output logic               pad_pd_o,
  output logic               analog_o
);

  logic [1:0] mode, cnf;
  logic       is_out, from_alt, open_drain, src, src_en, pulled;

  assign mode       = cfg_i[1:0];
  assign cnf        = cfg_i[3:2];
  assign is_out     = (mode != 2'b00);
  assign from_alt   = cnf[1];
  assign open_drain = cnf[0];

  always_comb begin
    src    = from_alt ? alt_out_i : odr_i;
    src_en = from_alt ? alt_oe_i  : 1'b1;
    if (!is_out) begin
      pad_out_o = 1'b0;
      pad_oe_o  = 1'b0;
    end else if (open_drain) begin
      pad_out_o = 1'b0;
      pad_oe_o  = src_en && !src;
    end else begin
      pad_out_o = src;
      pad_oe_o  = src_en;
    end
  end

  assign pulled   = !is_out && (cnf == 2'b10);
  assign pad_pu_o = pulled && odr_i;
  assign pad_pd_o = pulled && !odr_i;
  assign analog_o = !is_out && (cnf == 2'b00);

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       pad_in,
  output logic [15:0]       pad_out,
  output logic [15:0]       pad_oe,
  output logic [15:0]       pad_pu,
  output logic [15:0]       pad_pd,
  input  logic [15:0]       alt_out,
  input  logic [15:0]       alt_oe
);

  logic                          rst_meta_q, rst_sync_q;
  logic [NPINS-1:0][FIELD_W-1:0] cfg_w;
  logic [NPINS-1:0]              odr_w, idr_w, analog_w;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gpio_regfile #(.N(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .addr_i  (bus_addr),
    .we_i    (bus_we),
    .re_i    (bus_re),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .idr_i   (idr_w),
    .cfg_o   (cfg_w),
    .odr_o   (odr_w)
  );

  gpio_in_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pad_i    (pad_in),
    .analog_i (analog_w),
    .idr_o    (idr_w)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_drv u_drv (
      .cfg_i     (cfg_w[p]),
      .odr_i     (odr_w[p]),
      .alt_out_i (alt_out[p]),
      .alt_oe_i  (alt_oe[p]),
      .pad_out_o (pad_out[p]),
      .pad_oe_o  (pad_oe[p]),
      .pad_pu_o  (pad_pu[p]),
      .pad_pd_o  (pad_pd[p]),
      .analog_o  (analog_w[p])
    );

    assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
      ((cfg_w[p][1:0] != 2'b00) && cfg_w[p][2]) |-> !pad_out[p]);
    assert_input_undriven_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
      (cfg_w[p][1:0] == 2'b00) |-> !pad_oe[p]);
  end

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic [15:0] alt_out = '0;
  logic [15:0] alt_oe = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] W_LO = 3'd0, W_HI = 3'd1, W_IN = 3'd2, W_OUT = 3'd3,
                         W_SC = 3'd4, W_LK = 3'd5;

  always #4 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_out(alt_out), .alt_oe(alt_oe)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    peek(W_LO, d);  chk("R1 cfg lo after reset", d, 32'h4444_4444);
    peek(W_HI, d);  chk("R1 cfg hi after reset", d, 32'h4444_4444);
    peek(W_OUT, d); chk("R1 out after reset", d, 32'h0);
    peek(W_LK, d);  chk("R1 lock after reset", d, 32'h0);
    chk("R1 pad_oe after reset", {16'h0, pad_oe}, 32'h0);
    chk("R1 pulls after reset", {pad_pu, pad_pd}, 32'h0);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    @(negedge clk);
    pad_in = 16'hA5A5;
    @(negedge clk);
    @(negedge clk);
    peek(W_IN, d); chk("R10 input not yet visible after two edges", d, 32'h0);
    @(negedge clk);
    peek(W_IN, d); chk("R10 input visible on third edge", d, 32'h0000_A5A5);
  endtask

  task automatic t_analog();
    logic [31:0] d;
    wr(W_LO, 32'h4444_4440);
    peek(W_LO, d); chk("R2 cfg lo readback pin0 analog", d, 32'h4444_4440);
    @(negedge clk);
    peek(W_IN, d); chk("R9 analog pin0 reads zero", d, 32'h0000_A5A4);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(W_LO, 32'h4444_4420);
    wr(W_HI, 32'h4444_4434);
    peek(W_LO, d); chk("R2 cfg lo readback", d, 32'h4444_4420);
    peek(W_HI, d); chk("R2 cfg hi readback", d, 32'h4444_4434);
    chk("R5 push-pull outputs enabled on pins 1 and 9", {16'h0, pad_oe}, 32'h0000_0202);
    wr(W_OUT, 32'hFFFF_0202);
    peek(W_OUT, d); chk("R3 out upper half reads zero", d, 32'h0000_0202);
    #1 chk("R5 push-pull levels follow latch", {16'h0, pad_out}, 32'h0000_0202);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(W_SC, 32'h0200_0004);
    peek(W_OUT, d); chk("R4 clear pin9 set pin2", d, 32'h0000_0006);
    wr(W_SC, 32'h0002_0002);
    peek(W_OUT, d); chk("R4 set wins over clear", d, 32'h0000_0006);
    wr(W_SC, 32'h0004_0000);
    peek(W_OUT, d); chk("R4 clear only", d, 32'h0000_0002);
    peek(W_SC, d);  chk("R4 set/clear word reads zero", d, 32'h0);
    #1 chk("R5 pad levels after set/clear", {16'h0, pad_out}, 32'h0000_0002);
  endtask

  task automatic t_opendrain();
    wr(W_LO, 32'h4444_4450);
    #1 chk("R6 open-drain latch 1 releases pad", {31'h0, pad_oe[1]}, 32'h0);
    chk("R6 open-drain never drives high", {31'h0, pad_out[1]}, 32'h0);
    wr(W_SC, 32'h0002_0000);
    #1 chk("R6 open-drain latch 0 enables drive", {31'h0, pad_oe[1]}, 32'h1);
    chk("R6 open-drain drives low", {31'h0, pad_out[1]}, 32'h0);
  endtask

  task automatic t_alt();
    wr(W_HI, 32'h4444_44B4);
    @(negedge clk);
    alt_out[9] = 1'b1; alt_oe[9] = 1'b1;
    #1 chk("R7 alt push-pull level and enable", {30'h0, pad_out[9], pad_oe[9]}, 32'h3);
    alt_oe[9] = 1'b0;
    #1 chk("R7 alt enable gates drive", {31'h0, pad_oe[9]}, 32'h0);
    wr(W_HI, 32'h4444_44F4);
    alt_oe[9] = 1'b1;
    #1 chk("R7 alt open-drain high releases", {31'h0, pad_oe[9]}, 32'h0);
    alt_out[9] = 1'b0;
    #1 chk("R7 alt open-drain low drives", {30'h0, pad_out[9], pad_oe[9]}, 32'h1);
  endtask

  task automatic t_pull();
    wr(W_LO, 32'h44C4_8450);
    wr(W_SC, 32'h0000_0028);
    #1 chk("R8 pulled input with latch 1 pulls up", {30'h0, pad_pu[3], pad_pd[3]}, 32'h2);
    chk("R8 input pin not driven", {31'h0, pad_oe[3]}, 32'h0);
    chk("R8 configuration 11 input has no pull", {30'h0, pad_pu[5], pad_pd[5]}, 32'h0);
    wr(W_SC, 32'h0008_0000);
    #1 chk("R8 pulled input with latch 0 pulls down", {30'h0, pad_pu[3], pad_pd[3]}, 32'h1);
    chk("R8 floating input has no pull", {30'h0, pad_pu[4], pad_pd[4]}, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(W_LK, 32'h0001_0040);
    wr(W_LK, 32'h0000_0040);
    wr(W_LK, 32'h0001_0040);
    rd(W_LK, d); chk("R11 lock word before commit", d, 32'h0);
    rd(W_LK, d); chk("R11 lock word after commit", d, 32'h0001_0040);
    wr(W_LO, 32'h11C4_8450);
    peek(W_LO, d); chk("R11 locked pin6 unchanged, pin7 written", d, 32'h14C4_8450);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    wr(W_LK, 32'h0001_0080); wr(W_LK, 32'h0001_0080); wr(W_LK, 32'h0001_0080);
    rd(W_LK, d); rd(W_LK, d);
    chk("R12 wrong key aborts", d, 32'h0001_0040);
    wr(W_LK, 32'h0001_0080); wr(W_LK, 32'h0000_0100); wr(W_LK, 32'h0001_0080);
    rd(W_LK, d); rd(W_LK, d);
    chk("R12 changed mask aborts", d, 32'h0001_0040);
    wr(W_LK, 32'h0001_0080); wr(W_LK, 32'h0000_0080); rd(W_LK, d);
    wr(W_LK, 32'h0001_0080); rd(W_LK, d); rd(W_LK, d);
    chk("R12 early read aborts", d, 32'h0001_0040);
    wr(W_LO, 32'h2444_8450);
    peek(W_LO, d); chk("R12 unlocked pin7 still writable, pin6 kept", d, 32'h2444_8450);
  endtask

  task automatic t_reset_release();
    logic [31:0] d;
    do_reset();
    peek(W_LK, d); chk("R12 reset releases locks", d, 32'h0);
    wr(W_LO, 32'h4414_4444);
    peek(W_LO, d); chk("R12 pin6 writable after reset", d, 32'h4414_4444);
  endtask

  initial begin
    t_reset();
    t_sync();
    t_analog();
    t_layout();
    t_setclr();
    t_opendrain();
    t_alt();
    t_pull();
    t_lock();
    t_abort();
    t_reset_release();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule